// File: doc/BRIEF.md
# Waveform Timer Channel

A single up-counting timer channel that produces two waveform outputs and an interrupt. It is meant for periodic ticks and one-shot delays. A host programs the channel through a plain register write/read port. Each count step is one single-cycle enable pulse, taken from one of several tick sources. The current count is compared against three compare values, A, B and C. A match can set, clear or toggle the two outputs and raises a sticky status flag. A match on C can also do one of three things to the count: reset it, freeze it while the clock stays enabled, or freeze it and switch the clock off. A software trigger restarts the count from zero. This is how a one-shot delay is re-armed after a new C value is loaded.

A small control state machine sequences the channel. It has three states:
- `CH_OFF`: the clock is disabled.
- `CH_RUN`: the channel is counting.
- `CH_HELD`: the clock is enabled but the count is frozen after a C match.

Transitions:
- OFF→RUN on an enable command.
- RUN→OFF on a disable command, or on a C match with disable-on-C set.
- RUN→HELD on a C match with stop-on-C set.
- HELD→RUN on a software trigger.
- HELD→OFF on a disable command.
- RUN→RUN on a trigger, which restarts the count.

Register offsets (byte addresses):

| Offset | Register |
|---|---|
| 0x00 | command |
| 0x04 | mode |
| 0x10 | count (read-only) |
| 0x14 | compare A |
| 0x18 | compare B |
| 0x1C | compare C |
| 0x20 | status |
| 0x24 | interrupt-enable |
| 0x28 | interrupt-disable |
| 0x2C | interrupt mask |

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the count is 0, both outputs are low, irq is low, and the status and interrupt mask registers read 0. The channel is in `CH_OFF`.
- R2: A write to the command register controls the clock: bit 0 enables it and bit 1 disables it, and a disable wins over an enable in the same write. Status bit 16 reads 1 while the clock is enabled. The count advances by one on each pulse of the tick source selected by mode bits 2:0. It advances only in `CH_RUN` and only while mode bit 15 (waveform enable) is 1.
- R3: With mode bits 14:13 not equal to 2, the counter runs freely through C. A tick at the all-ones count wraps it to 0 and sets status bit 0 (overflow).
- R4: With mode bits 14:13 equal to 2, a tick taken while the count equals compare C loads 0 into the count.
- R5: A tick taken in `CH_RUN` while the count equals compare A, B or C sets status bit 2, 3 or 4 respectively.
- R6: Output A is driven by three action fields: the A match (mode 17:16), the C match (19:18) and the software trigger (23:22). Output B is driven by the B match (25:24), the C match (27:26) and the software trigger (31:30). Each field encodes 0 = none, 1 = set, 2 = clear, 3 = toggle.
- R7: Command bit 2 is the software trigger. While the clock is enabled, or together with an enable, it loads 0 into the count, enters `CH_RUN` and applies the trigger actions. While the clock is disabled it changes neither the count nor the outputs.
- R8: When several events drive one output in the same cycle, only the highest-priority event whose action is not none takes effect. The order is: software trigger, then C match, then A or B match.
- R9: With mode bit 6 set, a C match freezes the count at C and enters `CH_HELD` with the clock still enabled. A later trigger restarts counting from 0.
- R10: With mode bit 7 set, a C match freezes the count and disables the clock (`CH_OFF`). Status bit 16 then reads 0.
- R11: Reading status clears flag bits 0, 2, 3 and 4 unless an event sets them in the same cycle. Status bits 17 and 18 show the current levels of output A and output B.
- R12: Writing to 0x24 sets mask bits and writing to 0x28 clears mask bits. 0x2C reads the mask. irq is high exactly when some status flag bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_src | input | N_SRC | Single-cycle count enable pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears flags) |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| wave_a | output | 1 | Waveform output A |
| wave_b | output | 1 | Waveform output B |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- the count holds when there is neither a selected tick nor an accepted trigger, and holds in `CH_HELD`;
- a C match under disable-on-C lands in `CH_OFF`, and one under auto-reset lands on zero;
- an overflow event raises its flag;
- a set-on-trigger action drives output A high;
- a full mask clear drops irq;
- a status read with no concurrent event empties the flags.

Only the bench's scenarios show the rest: the exact waveform levels after sequences of compare matches, the resolution between a trigger and a C match arriving on the same edge, re-arming a one-shot, triggers ignored while off, tick-source selection, and a full 16-bit wrap.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_HELD = 2'd2
    } ch_state_t;

    localparam logic [7:0] ADR_CMD  = 8'h00;
    localparam logic [7:0] ADR_MODE = 8'h04;
    localparam logic [7:0] ADR_CNT  = 8'h10;
    localparam logic [7:0] ADR_CA   = 8'h14;
    localparam logic [7:0] ADR_CB   = 8'h18;
    localparam logic [7:0] ADR_CC   = 8'h1C;
    localparam logic [7:0] ADR_STAT = 8'h20;
    localparam logic [7:0] ADR_IEN  = 8'h24;
    localparam logic [7:0] ADR_IDS  = 8'h28;
    localparam logic [7:0] ADR_IMSK = 8'h2C;

    localparam logic [1:0] ACT_NONE = 2'd0;
    localparam logic [1:0] ACT_SET  = 2'd1;
    localparam logic [1:0] ACT_CLR  = 2'd2;
    localparam logic [1:0] ACT_TGL  = 2'd3;

    localparam logic [1:0] WT_UP_AUTO = 2'd2;

    function automatic logic apply_act(input logic [1:0] act, input logic cur);
        unique case (act)
            ACT_SET:  return 1'b1;
            ACT_CLR:  return 1'b0;
            ACT_TGL:  return ~cur;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wave_on,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_trg,
    input  logic [1:0]       wtype,
    input  logic             stop_c,
    input  logic             dis_c,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] cmp_c,
    output logic [CNT_W-1:0] count,
    output ch_state_t        state,
    output logic             ev_a,
    output logic             ev_b,
    output logic             ev_c,
    output logic             ev_ovf,
    output logic             ev_trg
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    ch_state_t        state_nxt;
    logic [CNT_W-1:0] count_nxt;
    logic             run_tick;
    logic             auto_rst;
    logic             c_freeze;

    assign run_tick = (state == CH_RUN) && tick && wave_on;
    assign auto_rst = (wtype == WT_UP_AUTO);
    assign c_freeze = stop_c || dis_c;

    assign ev_trg = cmd_trg && !cmd_dis && ((state != CH_OFF) || cmd_en);
    assign ev_a   = run_tick && (count == cmp_a);
    assign ev_b   = run_tick && (count == cmp_b);
    assign ev_c   = run_tick && (count == cmp_c);
    assign ev_ovf = run_tick && !ev_trg && (count == CNT_MAX)
                    && !(ev_c && (auto_rst || c_freeze));

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_OFF: begin
                if (cmd_en && !cmd_dis) state_nxt = CH_RUN;
            end
            CH_RUN: begin
                if (cmd_dis)              state_nxt = CH_OFF;
                else if (ev_trg)          state_nxt = CH_RUN;
                else if (ev_c && dis_c)   state_nxt = CH_OFF;
                else if (ev_c && stop_c)  state_nxt = CH_HELD;
            end
            CH_HELD: begin
                if (cmd_dis)      state_nxt = CH_OFF;
                else if (ev_trg)  state_nxt = CH_RUN;
            end
            default: state_nxt = CH_OFF;
        endcase
    end

    // counter datapath
    always_comb begin
        count_nxt = count;
        if (ev_trg) begin
            count_nxt = '0;
        end else if (run_tick) begin
            if (ev_c && c_freeze)       count_nxt = count;
            else if (ev_c && auto_rst)  count_nxt = '0;
            else                        count_nxt = count + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
            count <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
        end
    end

endmodule

// File: rtl/wtc_pin.sv
module wtc_pin
    import wtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_cmp,
    input  logic       ev_c,
    input  logic       ev_trg,
    input  logic [1:0] act_cmp,
    input  logic [1:0] act_c,
    input  logic [1:0] act_trg,
    output logic       level
);
    logic hit_trg, hit_c, hit_cmp;

    assign hit_trg = ev_trg && (act_trg != ACT_NONE);
    assign hit_c   = ev_c   && (act_c   != ACT_NONE);
    assign hit_cmp = ev_cmp && (act_cmp != ACT_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       level <= 1'b0;
        else if (hit_trg) level <= apply_act(act_trg, level);
        else if (hit_c)   level <= apply_act(act_c, level);
        else if (hit_cmp) level <= apply_act(act_cmp, level);
    end

endmodule

// File: rtl/wtc_regs.sv
module wtc_regs
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    input  logic             ev_a,
    input  logic             ev_b,
    input  logic             ev_c,
    input  logic             ev_ovf,
    input  logic [CNT_W-1:0] count,
    input  logic             clk_on,
    input  logic             lvl_a,
    input  logic             lvl_b,
    output logic [31:0]      mode,
    output logic [CNT_W-1:0] cmp_a,
    output logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] cmp_c,
    output logic             cmd_en,
    output logic             cmd_dis,
    output logic             cmd_trg,
    output logic [4:0]       flags,
    output logic [31:0]      rdata,
    output logic             irq
);
    logic [7:0] mask;
    logic [4:0] ev_vec;
    logic       wr_cmd, rd_stat;

    assign wr_cmd  = wr_en && (addr == ADR_CMD);
    assign cmd_en  = wr_cmd && wdata[0];
    assign cmd_dis = wr_cmd && wdata[1];
    assign cmd_trg = wr_cmd && wdata[2];
    assign rd_stat = rd_en && (addr == ADR_STAT);
    assign ev_vec  = {ev_c, ev_b, ev_a, 1'b0, ev_ovf};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode  <= '0;
            cmp_a <= '0;
            cmp_b <= '0;
            cmp_c <= '0;
            mask  <= '0;
            flags <= '0;
        end else begin
            flags <= (rd_stat ? 5'd0 : flags) | ev_vec;
            if (wr_en) begin
                unique case (addr)
                    ADR_MODE: mode  <= wdata;
                    ADR_CA:   cmp_a <= wdata[CNT_W-1:0];
                    ADR_CB:   cmp_b <= wdata[CNT_W-1:0];
                    ADR_CC:   cmp_c <= wdata[CNT_W-1:0];
                    ADR_IEN:  mask  <= mask | wdata[7:0];
                    ADR_IDS:  mask  <= mask & ~wdata[7:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_MODE: rdata = mode;
            ADR_CNT:  rdata = 32'(count);
            ADR_CA:   rdata = 32'(cmp_a);
            ADR_CB:   rdata = 32'(cmp_b);
            ADR_CC:   rdata = 32'(cmp_c);
            ADR_STAT: rdata = {13'd0, lvl_b, lvl_a, clk_on, 11'd0, flags};
            ADR_IMSK: rdata = {24'd0, mask};
            default:  rdata = '0;
        endcase
    end

    assign irq = |(flags & mask[4:0]);

endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] tick_src,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             wave_a,
    output logic             wave_b,
    output logic             irq
);
    localparam int SEL_W   = 3;
    localparam int SEL_CNT = 1 << SEL_W;

    logic [31:0]      mode;
    logic [CNT_W-1:0] cmp_a, cmp_b, cmp_c, count;
    logic             cmd_en, cmd_dis, cmd_trg;
    logic             ev_a, ev_b, ev_c, ev_ovf, ev_trg;
    logic [4:0]       flags;
    ch_state_t        st;
    logic [SEL_CNT-1:0] src_ext;
    logic             tick_sel;

    logic [1:0]       ev_cmp;
    logic [1:0]       lvl;
    logic [1:0][1:0]  act_cmp, act_c, act_trg;

    always_comb begin
        src_ext = '0;
        src_ext[N_SRC-1:0] = tick_src;
    end
    assign tick_sel = src_ext[mode[SEL_W-1:0]];

    wtc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata),
        .ev_a(ev_a), .ev_b(ev_b), .ev_c(ev_c), .ev_ovf(ev_ovf),
        .count(count), .clk_on(st != CH_OFF),
        .lvl_a(lvl[0]), .lvl_b(lvl[1]),
        .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trg(cmd_trg),
        .flags(flags), .rdata(rdata), .irq(irq)
    );

    wtc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick_sel), .wave_on(mode[15]),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trg(cmd_trg),
        .wtype(mode[14:13]), .stop_c(mode[6]), .dis_c(mode[7]),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
        .count(count), .state(st),
        .ev_a(ev_a), .ev_b(ev_b), .ev_c(ev_c), .ev_ovf(ev_ovf), .ev_trg(ev_trg)
    );

    assign ev_cmp     = {ev_b, ev_a};
    assign act_cmp[0] = mode[17:16];
    assign act_c[0]   = mode[19:18];
    assign act_trg[0] = mode[23:22];
    assign act_cmp[1] = mode[25:24];
    assign act_c[1]   = mode[27:26];
    assign act_trg[1] = mode[31:30];

    for (genvar g = 0; g < 2; g++) begin : g_pin
        wtc_pin u_pin (
            .clk(clk), .rst_n(rst_n),
            .ev_cmp(ev_cmp[g]), .ev_c(ev_c), .ev_trg(ev_trg),
            .act_cmp(act_cmp[g]), .act_c(act_c[g]), .act_trg(act_trg[g]),
            .level(lvl[g])
        );
    end

    assign wave_a = lvl[0];
    assign wave_b = lvl[1];

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_sel,
    input logic             ev_trg,
    input logic             ev_a,
    input logic             ev_b,
    input logic             ev_c,
    input logic             ev_ovf,
    input ch_state_t        st,
    input logic [CNT_W-1:0] count,
    input logic [31:0]      mode,
    input logic [4:0]       flags,
    input logic             wr_en,
    input logic             rd_en,
    input logic [7:0]       addr,
    input logic [31:0]      wdata,
    input logic             wave_a,
    input logic             irq
);
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_sel && !ev_trg |=> $stable(count));

    assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ovf |=> flags[0]);

    assert_auto_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_c && mode[14:13] == WT_UP_AUTO && !mode[6] && !mode[7] && !ev_trg
        |=> count == '0);

    assert_trg_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_trg && mode[23:22] == ACT_SET |=> wave_a);

    assert_held_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st == CH_HELD && !ev_trg |=> $stable(count));

    assert_dis_on_c_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st == CH_RUN && ev_c && mode[7] && !ev_trg |=> st == CH_OFF);

    assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == ADR_STAT && !ev_a && !ev_b && !ev_c && !ev_ovf
        |=> flags == 5'd0);

    assert_mask_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == ADR_IDS && wdata[7:0] == 8'hFF |=> !irq);

endmodule

bind wave_timer_chan wtc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_sel(tick_sel), .ev_trg(ev_trg),
    .ev_a(ev_a), .ev_b(ev_b), .ev_c(ev_c), .ev_ovf(ev_ovf),
    .st(st), .count(count), .mode(mode), .flags(flags),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .wave_a(wave_a), .irq(irq)
);

// File: tb/test_wave_timer_chan.sv
module test_wave_timer_chan;
    localparam int N_SRC = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] tick_src = '0;
    logic             wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             wave_a, wave_b, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wave_timer_chan #(.CNT_W(16), .N_SRC(N_SRC)) i_wave_timer_chan (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  wt;
        logic        stp;
        logic [1:0]  aa, ac, bb, bc;
        logic [15:0] ra, rb, rc;
        logic [16:0] n;
        logic [15:0] ecnt;
        logic        ea, eb;
        logic [4:0]  est;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{2'd0, 1'b0, 2'd1, 2'd2, 2'd3, 2'd0, 16'd2, 16'd3, 16'd5, 17'd4, 16'd4, 1'b1, 1'b1, 5'b01100},
        '{2'd0, 1'b0, 2'd1, 2'd2, 2'd3, 2'd0, 16'd2, 16'd3, 16'd5, 17'd7, 16'd7, 1'b0, 1'b1, 5'b11100},
        '{2'd2, 1'b0, 2'd3, 2'd0, 2'd0, 2'd3, 16'd1, 16'd0, 16'd3, 17'd9, 16'd1, 1'b0, 1'b0, 5'b11100},
        '{2'd2, 1'b1, 2'd0, 2'd1, 2'd0, 2'd0, 16'hFFFF, 16'hFFFF, 16'd2, 17'd6, 16'd2, 1'b1, 1'b0, 5'b10000}
    };

    function automatic logic [31:0] mk(input logic [1:0] wt, input logic stp, dsb,
                                       input logic [1:0] aa, ac, asw, bb, bc, bsw,
                                       input logic [2:0] sel);
        return {bsw, 2'b00, bc, bb, asw, 2'b00, ac, aa,
                1'b1, wt, 5'd0, dsb, stp, 3'd0, sel};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; rd_en = 0; tick_src = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(input int s, input int n);
        @(negedge clk);
        tick_src[s] = 1'b1;
        repeat (n) @(negedge clk);
        tick_src[s] = 1'b0;
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;

        // R1 reset state
        do_reset();
        chk("R1 wave_a", 32'(wave_a), 0);
        chk("R1 wave_b", 32'(wave_b), 0);
        chk("R1 irq", 32'(irq), 0);
        rd(8'h10, v); chk("R1 count", v, 0);
        rd(8'h20, v); chk("R1 status", v, 0);
        rd(8'h2C, v); chk("R1 mask", v, 0);

        // table: R5 R6 R3 R4 R9 R11
        for (int i = 0; i < 4; i++) begin
            do_reset();
            wr(8'h04, mk(VECS[i].wt, VECS[i].stp, 1'b0, VECS[i].aa, VECS[i].ac, 2'd0,
                         VECS[i].bb, VECS[i].bc, 2'd0, 3'd0));
            wr(8'h14, 32'(VECS[i].ra));
            wr(8'h18, 32'(VECS[i].rb));
            wr(8'h1C, 32'(VECS[i].rc));
            wr(8'h00, 32'h5);
            ticks(0, int'(VECS[i].n));
            rd(8'h10, v); chk($sformatf("R4 vec%0d count", i), v, 32'(VECS[i].ecnt));
            chk($sformatf("R6 vec%0d wave_a", i), 32'(wave_a), 32'(VECS[i].ea));
            chk($sformatf("R6 vec%0d wave_b", i), 32'(wave_b), 32'(VECS[i].eb));
            rd(8'h20, v);
            chk($sformatf("R5 vec%0d flags", i), 32'(v[4:0]), 32'(VECS[i].est));
            chk($sformatf("R11 vec%0d mirrors", i), 32'(v[18:16]),
                32'({VECS[i].eb, VECS[i].ea, 1'b1}));
        end

        // R10 disable on C, then R7 trigger ignored while off
        do_reset();
        wr(8'h04, mk(2'd0, 1'b0, 1'b1, 2'd0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 3'd0));
        wr(8'h14, 32'hFFFF); wr(8'h18, 32'hFFFF); wr(8'h1C, 32'd1);
        wr(8'h00, 32'h1);
        ticks(0, 4);
        rd(8'h10, v); chk("R10 count frozen", v, 1);
        chk("R10 wave_a toggled", 32'(wave_a), 1);
        rd(8'h20, v); chk("R10 clock off", 32'(v[16]), 0);
        chk("R10 C flag", 32'(v[4]), 1);
        wr(8'h04, mk(2'd0, 1'b0, 1'b1, 2'd0, 2'd3, 2'd3, 2'd0, 2'd0, 2'd0, 3'd0));
        wr(8'h00, 32'h4);
        rd(8'h10, v); chk("R7 trigger off count", v, 1);
        chk("R7 trigger off wave_a", 32'(wave_a), 1);

        // R9 one-shot held and rearm, R7 trigger action
        do_reset();
        wr(8'h04, mk(2'd2, 1'b1, 1'b0, 2'd0, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0, 3'd0));
        wr(8'h14, 32'hFFFF); wr(8'h18, 32'hFFFF); wr(8'h1C, 32'd3);
        wr(8'h00, 32'h1);
        ticks(0, 5);
        rd(8'h10, v); chk("R9 held count", v, 3);
        rd(8'h20, v); chk("R9 clock still on", 32'(v[16]), 1);
        wr(8'h1C, 32'd1);
        wr(8'h00, 32'h4);
        chk("R7 trigger set wave_a", 32'(wave_a), 1);
        rd(8'h10, v); chk("R7 trigger zero count", v, 0);
        ticks(0, 1);
        rd(8'h10, v); chk("R9 rearm counts", v, 1);
        ticks(0, 2);
        rd(8'h10, v); chk("R9 held again", v, 1);
        chk("R9 C clear wave_a", 32'(wave_a), 0);

        // R8 trigger beats C beats A
        do_reset();
        wr(8'h04, mk(2'd0, 1'b0, 1'b0, 2'd3, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 3'd0));
        wr(8'h14, 32'd2); wr(8'h18, 32'hFFFF); wr(8'h1C, 32'd2);
        wr(8'h00, 32'h1);
        ticks(0, 2);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h00; wdata = 32'h4; tick_src[0] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_src[0] = 1'b0;
        chk("R8 trigger wins wave_a", 32'(wave_a), 0);
        rd(8'h10, v); chk("R8 trigger restarts count", v, 0);
        do_reset();
        wr(8'h04, mk(2'd0, 1'b0, 1'b0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd0, 2'd0, 3'd0));
        wr(8'h14, 32'd1); wr(8'h18, 32'hFFFF); wr(8'h1C, 32'd1);
        wr(8'h00, 32'h1);
        ticks(0, 2);
        chk("R8 C wins over A", 32'(wave_a), 0);

        // R12 interrupt mask
        do_reset();
        wr(8'h04, mk(2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 3'd0));
        wr(8'h14, 32'hFFFF); wr(8'h18, 32'hFFFF); wr(8'h1C, 32'd1);
        wr(8'h24, 32'h10);
        rd(8'h2C, v); chk("R12 mask readback", v, 32'h10);
        chk("R12 irq quiet", 32'(irq), 0);
        wr(8'h00, 32'h1);
        ticks(0, 2);
        chk("R12 irq on C", 32'(irq), 1);
        wr(8'h28, 32'h10);
        chk("R12 irq masked", 32'(irq), 0);
        wr(8'h24, 32'h10);
        chk("R12 irq unmasked", 32'(irq), 1);
        rd(8'h20, v);
        chk("R11 irq after read", 32'(irq), 0);
        rd(8'h20, v); chk("R11 flags cleared", 32'(v[4:0]), 0);

        // R2 tick select, waveform enable, disable priority
        do_reset();
        wr(8'h04, mk(2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 3'd1));
        wr(8'h1C, 32'hFFFF);
        wr(8'h00, 32'h1);
        ticks(0, 3);
        rd(8'h10, v); chk("R2 other source ignored", v, 0);
        ticks(1, 3);
        rd(8'h10, v); chk("R2 selected source counts", v, 3);
        wr(8'h04, 32'h0000_0001);
        ticks(1, 3);
        rd(8'h10, v); chk("R2 waveform bit off", v, 3);
        wr(8'h00, 32'h3);
        rd(8'h20, v); chk("R2 disable wins", 32'(v[16]), 0);

        // R3 full wrap
        do_reset();
        wr(8'h04, mk(2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 3'd0));
        wr(8'h14, 32'hFFFF); wr(8'h18, 32'hFFFF); wr(8'h1C, 32'hFFFF);
        wr(8'h00, 32'h1);
        ticks(0, 65536);
        rd(8'h10, v); chk("R3 wrap count", v, 0);
        rd(8'h20, v); chk("R3 overflow flag", 32'(v[4:0]), 32'b11101);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule